// File: doc/BRIEF.md
# Processor Mode and Status Controller

This block keeps the processor's current status word and a saved copy of that word for each exception mode. It also decides every change of privilege mode. Three kinds of request reach it. Software writes arrive with a per-byte lane mask. Exception entries arrive as five event pins: IRQ, FIQ, prefetch abort, data abort and undefined instruction. Exception returns arrive on their own pin. From these it builds the next status word, the next mode, the interrupt masks and the saved copies.

The mode lives in bits 4:0 of the status word. Bit 7 masks IRQ and bit 6 masks FIQ. Every request pin is a single-cycle strobe, and the controller accepts one in every cycle. There is therefore no back-pressure, and a strobe that is held high acts once per cycle. All results are registered. The status word, the trap pulse and the return-error pulse change on the clock edge that samples the request. Reset puts the block in supervisor mode with both interrupts masked.

Top module: `mode_status_ctrl`

## Requirements
- R1: Reset sets the status word to 0x000000D3 (supervisor mode, both masks set) and every saved copy to 0x00000010. The trap and return-error outputs are low after reset.
- R2: The valid mode codes are 0x10 user, 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. The mode output always holds one of these codes. The privileged output is high in every mode except user.
- R3: In a privileged mode, a software write replaces each byte lane whose mask bit is set (lane k covers bits 8k+7:8k). Lanes whose mask bit is clear keep their value. The result is visible one cycle later.
- R4: In user mode, lane 0 of a software write (mode field and mask bits) is ignored. The upper lanes are still written as selected.
- R5: A software write that selects lane 0 with a mode code outside the valid set is dropped in every lane. The trap output then pulses high for exactly one cycle, in the cycle after the request.
- R6: Exception entry sets the mode as follows: IRQ to 0x12, FIQ to 0x11, prefetch abort and data abort to 0x17, undefined to 0x1B. Entry always sets bit 7 and sets bit 6 only for FIQ. Every other bit is kept.
- R7: On entry, the status word held before the event is stored into the saved copy of the target mode in the same cycle. The saved-copy output shows the copy of the current mode, or zero in user and system mode.
- R8: When several exception pins are high in one cycle, the winner is chosen in this order: data abort, FIQ, IRQ, prefetch abort, undefined.
- R9: An exception return in a mode that has a saved copy loads that copy into the status word. In user or system mode the return is ignored, and the return-error output pulses for one cycle.
- R10: If requests of different kinds arrive in the same cycle, exception entry wins over return, and return wins over software write. The losing requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | PSR_W | Write data |
| wr_lanes | input | PSR_W/8 | Byte-lane select for the write |
| exc_irq | input | 1 | IRQ entry event |
| exc_fiq | input | 1 | FIQ entry event |
| exc_pabt | input | 1 | Prefetch abort entry event |
| exc_dabt | input | 1 | Data abort entry event |
| exc_und | input | 1 | Undefined-instruction entry event |
| ret_en | input | 1 | Exception-return strobe |
| psr_o | output | PSR_W | Current status word |
| mode_o | output | 5 | Current mode code |
| priv_o | output | 1 | High outside user mode |
| saved_o | output | PSR_W | Saved copy of the current mode |
| trap_o | output | 1 | Undefined-instruction trap pulse |
| ret_err_o | output | 1 | Pulse for a return with no saved copy |

## Verification
The bench targets cycles where several requests collide. An entry that loses to a write would leave the interrupt mask clear. A wrong priority order would save the old status into the wrong mode's copy, and that shows up on the next return. It also sends invalid mode codes with lane 0 selected. A design that merged only the upper lanes would corrupt the word, and one that loaded the code would leave an illegal mode. Finally, it issues returns from user and system mode and writes to the control byte from user mode. A design that let either through would raise privilege without an exception.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int MODE_W      = 5;
  localparam int NBANK       = 5;
  localparam int BANK_IDX_W  = 3;
  localparam int IRQ_MSK_BIT = 7;
  localparam int FIQ_MSK_BIT = 6;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10,
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_UND = 5'h1B,
    M_SYS = 5'h1F
  } mode_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: mode_ok = 1'b1;
      default: mode_ok = 1'b0;
    endcase
  endfunction

  function automatic logic has_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: has_bank = 1'b1;
      default: has_bank = 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd0;
      M_IRQ:   bank_of = 3'd1;
      M_SVC:   bank_of = 3'd2;
      M_ABT:   bank_of = 3'd3;
      M_UND:   bank_of = 3'd4;
      default: bank_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/msc_exc_arb.sv
module msc_exc_arb
  import msc_pkg::*;
(
  input  logic              dabt,
  input  logic              fiq,
  input  logic              irq,
  input  logic              pabt,
  input  logic              und,
  output logic              take,
  output logic [MODE_W-1:0] tgt,
  output logic              fiq_sel
);
  always_comb begin
    take    = 1'b1;
    fiq_sel = 1'b0;
    tgt     = M_SVC;
    if (dabt) begin
      tgt = M_ABT;
    end else if (fiq) begin
      tgt     = M_FIQ;
      fiq_sel = 1'b1;
    end else if (irq) begin
      tgt = M_IRQ;
    end else if (pabt) begin
      tgt = M_ABT;
    end else if (und) begin
      tgt = M_UND;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/msc_wr_merge.sv
module msc_wr_merge
  import msc_pkg::*;
#(
  parameter int PSR_W = 32
) (
  input  logic [PSR_W-1:0]   cur,
  input  logic [PSR_W-1:0]   data,
  input  logic [PSR_W/8-1:0] lane_en,
  input  logic               is_user,
  output logic [PSR_W-1:0]   nxt,
  output logic               trap
);
  localparam int NLANE = PSR_W / 8;

  logic [NLANE-1:0] lane_ok;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    if (i == 0) begin : g_ctrl
      assign lane_ok[i] = lane_en[i] & ~is_user;
    end else begin : g_data
      assign lane_ok[i] = lane_en[i];
    end
    assign nxt[8*i +: 8] = lane_ok[i] ? data[8*i +: 8] : cur[8*i +: 8];
  end

  assign trap = lane_en[0] & ~mode_ok(data[MODE_W-1:0]);
endmodule

// File: rtl/msc_saved_bank.sv
module msc_saved_bank
  import msc_pkg::*;
#(
  parameter int PSR_W = 32,
  parameter int NB    = NBANK,
  parameter logic [PSR_W-1:0] RST_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [BANK_IDX_W-1:0] widx,
  input  logic [PSR_W-1:0]      wdata,
  input  logic [BANK_IDX_W-1:0] ridx,
  output logic [PSR_W-1:0]      rdata
);
  logic [PSR_W-1:0] regs [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) regs[b] <= RST_VAL;
    end else if (we) begin
      for (int b = 0; b < NB; b++)
        if (widx == BANK_IDX_W'(b)) regs[b] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++)
      if (ridx == BANK_IDX_W'(b)) rdata = regs[b];
  end
endmodule

// File: rtl/mode_status_ctrl.sv
module mode_status_ctrl
  import msc_pkg::*;
#(
  parameter int PSR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PSR_W-1:0]   wr_data,
  input  logic [PSR_W/8-1:0] wr_lanes,
  input  logic               exc_irq,
  input  logic               exc_fiq,
  input  logic               exc_pabt,
  input  logic               exc_dabt,
  input  logic               exc_und,
  input  logic               ret_en,
  output logic [PSR_W-1:0]   psr_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               priv_o,
  output logic [PSR_W-1:0]   saved_o,
  output logic               trap_o,
  output logic               ret_err_o
);
  localparam logic [PSR_W-1:0] RST_PSR   = {{(PSR_W-8){1'b0}}, 3'b110, M_SVC};
  localparam logic [PSR_W-1:0] SAVED_RST = {{(PSR_W-MODE_W){1'b0}}, M_USR};

  logic [PSR_W-1:0]      psr_q, psr_d, merged, bank_rd;
  logic                  trap_q, trap_d, rerr_q, rerr_d;
  logic [MODE_W-1:0]     cur_mode, tgt;
  logic                  take, fiq_sel, merge_trap, cur_banked, is_user;

  assign cur_mode   = psr_q[MODE_W-1:0];
  assign is_user    = (cur_mode == M_USR);
  assign cur_banked = has_bank(cur_mode);

  msc_exc_arb u_arb (
    .dabt    (exc_dabt),
    .fiq     (exc_fiq),
    .irq     (exc_irq),
    .pabt    (exc_pabt),
    .und     (exc_und),
    .take    (take),
    .tgt     (tgt),
    .fiq_sel (fiq_sel)
  );

  msc_saved_bank #(.PSR_W(PSR_W), .NB(NBANK), .RST_VAL(SAVED_RST)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (take),
    .widx  (bank_of(tgt)),
    .wdata (psr_q),
    .ridx  (bank_of(cur_mode)),
    .rdata (bank_rd)
  );

  msc_wr_merge #(.PSR_W(PSR_W)) u_merge (
    .cur     (psr_q),
    .data    (wr_data),
    .lane_en (wr_lanes),
    .is_user (is_user),
    .nxt     (merged),
    .trap    (merge_trap)
  );

  always_comb begin
    psr_d  = psr_q;
    trap_d = 1'b0;
    rerr_d = 1'b0;
    if (take) begin
      psr_d[MODE_W-1:0]  = tgt;
      psr_d[IRQ_MSK_BIT] = 1'b1;
      if (fiq_sel) psr_d[FIQ_MSK_BIT] = 1'b1;
    end else if (ret_en) begin
      if (cur_banked) psr_d = bank_rd;
      else            rerr_d = 1'b1;
    end else if (wr_en) begin
      if (merge_trap) trap_d = 1'b1;
      else            psr_d  = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q  <= RST_PSR;
      trap_q <= 1'b0;
      rerr_q <= 1'b0;
    end else begin
      psr_q  <= psr_d;
      trap_q <= trap_d;
      rerr_q <= rerr_d;
    end
  end

  assign psr_o     = psr_q;
  assign mode_o    = cur_mode;
  assign priv_o    = ~is_user;
  assign saved_o   = cur_banked ? bank_rd : '0;
  assign trap_o    = trap_q;
  assign ret_err_o = rerr_q;
endmodule

// File: rtl/msc_checker.sv
module msc_checker
  import msc_pkg::*;
#(
  parameter int PSR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_irq,
  input logic              exc_fiq,
  input logic              exc_pabt,
  input logic              exc_dabt,
  input logic              exc_und,
  input logic [PSR_W-1:0]  psr_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              priv_o,
  input logic              trap_o,
  input logic              ret_err_o
);
  logic exc_any;
  assign exc_any = exc_irq | exc_fiq | exc_pabt | exc_dabt | exc_und;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(mode_o)); // R2

  AST_USER_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!priv_o && !exc_any) |-> psr_o[7:0] == $past(psr_o[7:0])); // R4

  AST_TRAP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $stable(psr_o)); // R5

  AST_ENTRY_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exc_any) |-> psr_o[IRQ_MSK_BIT]); // R6

  AST_FIQ_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exc_fiq && !exc_dabt) |-> (mode_o == M_FIQ) && psr_o[FIQ_MSK_BIT]); // R8

  AST_RETERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err_o |-> $stable(psr_o)); // R9

  AST_ONE_KIND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_o && ret_err_o)); // R10
endmodule

bind mode_status_ctrl msc_checker #(.PSR_W(PSR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_irq   (exc_irq),
  .exc_fiq   (exc_fiq),
  .exc_pabt  (exc_pabt),
  .exc_dabt  (exc_dabt),
  .exc_und   (exc_und),
  .psr_o     (psr_o),
  .mode_o    (mode_o),
  .priv_o    (priv_o),
  .trap_o    (trap_o),
  .ret_err_o (ret_err_o)
);

// File: tb/mode_status_ctrl_bench.sv
`timescale 1ns/1ps
module mode_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_lanes = '0;
  logic        exc_irq = 0, exc_fiq = 0, exc_pabt = 0, exc_dabt = 0, exc_und = 0;
  logic        ret_en = 1'b0;
  logic [31:0] psr_o, saved_o;
  logic [4:0]  mode_o;
  logic        priv_o, trap_o, ret_err_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mode_status_ctrl #(.PSR_W(32)) u_mode_status_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_lanes(wr_lanes),
    .exc_irq(exc_irq), .exc_fiq(exc_fiq), .exc_pabt(exc_pabt), .exc_dabt(exc_dabt),
    .exc_und(exc_und), .ret_en(ret_en), .psr_o(psr_o), .mode_o(mode_o), .priv_o(priv_o),
    .saved_o(saved_o), .trap_o(trap_o), .ret_err_o(ret_err_o)
  );

  typedef struct {
    logic [31:0] psr;
    logic [31:0] sv;
    logic        trap;
    logic        rerr;
    logic        priv;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_psr;
  logic [31:0] m_sv [5];

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit valid_mode(input logic [4:0] m);
    return (m == 5'h10) || (m == 5'h1F) || (bidx(m) >= 0);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // ex = {dabt, fiq, irq, pabt, und}
  task automatic step(input logic we, input logic [31:0] d, input logic [3:0] ln,
                      input logic [4:0] ex, input logic rt, input string tag);
    exp_t e;
    logic [4:0] tgt;
    int bi;
    wr_en = we; wr_data = d; wr_lanes = ln; ret_en = rt;
    {exc_dabt, exc_fiq, exc_irq, exc_pabt, exc_und} = ex;
    e.trap = 0; e.rerr = 0;
    if (ex != 0) begin
      if (ex[4]) tgt = 5'h17;
      else if (ex[3]) tgt = 5'h11;
      else if (ex[2]) tgt = 5'h12;
      else if (ex[1]) tgt = 5'h17;
      else tgt = 5'h1B;
      m_sv[bidx(tgt)] = m_psr;
      m_psr[4:0] = tgt;
      m_psr[7] = 1'b1;
      if (tgt == 5'h11) m_psr[6] = 1'b1;
    end else if (rt) begin
      bi = bidx(m_psr[4:0]);
      if (bi < 0) e.rerr = 1;
      else m_psr = m_sv[bi];
    end else if (we) begin
      if (ln[0] && !valid_mode(d[4:0])) e.trap = 1;
      else begin
        for (int i = 0; i < 4; i++)
          if (ln[i] && !(i == 0 && m_psr[4:0] == 5'h10)) m_psr[8*i +: 8] = d[8*i +: 8];
      end
    end
    bi = bidx(m_psr[4:0]);
    e.sv = (bi < 0) ? 32'h0 : m_sv[bi];
    e.psr = m_psr;
    e.priv = (m_psr[4:0] != 5'h10);
    e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "psr", psr_o, e.psr);
      chk(e.tag, "saved (R7)", saved_o, e.sv);
      chk(e.tag, "trap (R5)", {31'h0, trap_o}, {31'h0, e.trap});
      chk(e.tag, "ret_err (R9)", {31'h0, ret_err_o}, {31'h0, e.rerr});
      chk(e.tag, "priv (R2)", {31'h0, priv_o}, {31'h0, e.priv});
      chk(e.tag, "mode (R2)", {27'h0, mode_o}, {27'h0, e.psr[4:0]});
    end
  end

  initial begin
    m_psr = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sv[i] = 32'h0000_0010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset psr", psr_o, 32'h0000_00D3);
    chk("R1", "reset saved", saved_o, 32'h0000_0010);
    chk("R1", "reset pulses", {30'h0, trap_o, ret_err_o}, 32'h0);

    step(0, 0, 4'h0, 5'b00000, 1, "R9 return from supervisor");
    step(1, 32'hA500_00DF, 4'hF, 5'b00000, 0, "R4 user write");
    step(1, 32'h0000_0005, 4'h1, 5'b00000, 0, "R5 invalid mode in user");
    step(0, 0, 4'h0, 5'b00000, 1, "R9 return in user");
    step(0, 0, 4'h0, 5'b00100, 0, "R6 irq entry");
    step(0, 0, 4'h0, 5'b00000, 1, "R9 irq return");
    step(0, 0, 4'h0, 5'b11100, 0, "R8 dabt beats fiq irq");
    step(0, 0, 4'h0, 5'b01100, 0, "R8 fiq beats irq");
    step(1, 32'h0000_001F, 4'h1, 5'b00001, 1, "R10 entry beats return and write");
    step(1, 32'h0000_001F, 4'h1, 5'b00000, 1, "R10 return beats write");
    step(1, 32'h0000_001F, 4'h1, 5'b00000, 0, "R3 priv write to system");
    step(0, 0, 4'h0, 5'b00000, 1, "R9 return in system");
    step(1, 32'h1234_56EE, 4'hE, 5'b00000, 0, "R3 upper lanes only");
    step(1, 32'hFFFF_FF00, 4'h3, 5'b00000, 0, "R5 invalid mode privileged");
    step(0, 0, 4'h0, 5'b00010, 0, "R6 prefetch abort entry");
    step(0, 0, 4'h0, 5'b00001, 0, "R6 undefined entry");
    step(0, 0, 4'h0, 5'b00011, 0, "R8 pabt beats und");
    step(0, 0, 4'h0, 5'b00000, 1, "R7 return restores saved");
    foreach (m_sv[k]) begin : g_modes
      logic [4:0] mv;
      case (k)
        0: mv = 5'h11; 1: mv = 5'h12; 2: mv = 5'h13; 3: mv = 5'h17; default: mv = 5'h1B;
      endcase
      step(1, {27'h0, mv}, 4'h1, 5'b00000, 0, "R2 write valid mode");
      step(1, 32'h0000_001F, 4'h1, 5'b00000, 0, "R2 back to system");
    end
    step(1, 32'h0000_0010, 4'h1, 5'b00000, 0, "R2 drop to user");
    step(1, 32'h0000_001F, 4'h1, 5'b00000, 0, "R4 user cannot raise");
    step(0, 0, 4'h0, 5'b01000, 0, "R6 fiq entry from user");
    wr_en = 0; ret_en = 0; wr_lanes = 0;
    {exc_dabt, exc_fiq, exc_irq, exc_pabt, exc_und} = 5'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule